// File: doc/BRIEF.md
# Manchester-Coded Sensor Bus Slave

This block is the module-side end of a two-wire sensor bus. A single controller drives the bus clock and the shared data line. Each bit cell spans two clock periods and carries one of four half-cell pairs. Two of these pairs carry the data values 1 and 0. The two pairs that hold a level for the whole cell mark where a message starts and ends. The block samples one half-cell on every rising edge of the bus clock. It waits for a start mark and then collects an eight-bit address word. When the module part of that word equals the strapped address pins, the block selects one of sixteen sensor channels. For a fixed window it then puts that channel's frequency signal onto the data line. During this window the path from the frequency input to the line has no register in it.

The block can also speak on its own behalf. An interrupt request can be disabled by a configuration input. When enabled, it goes out at once, even while the controller is in the middle of a frame or the module is streaming. A service request waits until the receiver is idle and the line is high. Both pads are open-drain, so the block never drives a high level. It only asserts an output enable that pulls the data line low.

Top module: `mcs_sensor_slave`

## Requirements
- R1: While reset is asserted and right after it is released, `dl_oe`, `chan_valid` and `frame_err` are all low.
- R2: A frame consists of these cells in order. It starts with a start cell, which is low then low. Eight bit cells follow: 1 is high then low and 0 is low then high. The first four bits are the channel number, most significant bit first. The next four bits are the module number, also most significant bit first. An end cell closes the frame, which is high then high. If the module number equals `mod_addr`, then after the edge that samples the last half of the end cell, `chan_valid` is high and `chan_sel` shows the channel number.
- R3: While `chan_valid` is high, `dl_oe` equals the inverse of `freq_in[chan_sel]`, combinationally. `chan_sel` holds steady. After exactly STREAM_HALVES further clock edges, `chan_valid` falls and the line is released.
- R4: A frame with a different module number selects nothing. The block ignores the data line for the next STREAM_HALVES edges, so a peer's stream raises no error and starts no frame. During that window `dl_oe` stays low.
- R5: Any of these is a framing error: a start cell whose second half is high, a start or end cell among the eight bits, or anything other than an end cell after the eighth bit. After the edge that samples the bad half, `frame_err` pulses high for one cycle. The receiver then returns to waiting for a start cell and selects nothing.
- R6: If `irq_en` is high at the edge that samples `irq_req`, `dl_oe` is high for IRQ_HALVES cycles, starting one edge later. This overrides a stream in progress but does not stretch it.
- R7: An `irq_req` sampled while `irq_en` is low is dropped. It is not sent later when `irq_en` rises.
- R8: An interrupt sent while a frame is being received abandons that frame and does not flag a framing error. The next frame is received normally.
- R9: A service request, raised on `srq_req`, is sent only when the receiver is idle and the line is sampled high. A request made during a stream is held until the stream ends. It pulls the line low for SRQ_HALVES cycles.
- R10: When an interrupt and a service request are pending together, the interrupt goes out first and the service request follows.
- R11: `dl_oe` is low whenever the block is neither streaming nor sending a request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock line; each rising edge samples one half-cell |
| rst_n | input | 1 | Asynchronous active-low reset |
| dl_in | input | 1 | Level sensed on the shared data line |
| mod_addr | input | MOD_W | Strapped module address |
| freq_in | input | N_CH | Frequency outputs of the sensor channels |
| irq_req | input | 1 | Interrupt request pulse |
| irq_en | input | 1 | Interrupt enable (configuration) |
| srq_req | input | 1 | Service request pulse |
| dl_oe | output | 1 | Pulls the data line low when high |
| chan_sel | output | log2(N_CH) | Selected channel, valid with chan_valid |
| chan_valid | output | 1 | Selected channel is streaming |
| frame_err | output | 1 | One-cycle framing error pulse |

## Verification
The bench changes the line level on falling edges and reads results at the next falling edge, so each input half-cell is sampled by exactly one rising edge. Selection and framing errors appear one edge after the half that decides them. A stream lasts STREAM_HALVES edges counted from that point. A request is latched on the edge that samples the pulse and reaches the line one edge later, so the bench counts forward from the pulse. Stream routing is combinational, so it is checked one time step after `freq_in` changes, with no clock edge in between. The bench sweeps every channel and every non-matching module number.

// File: rtl/mcs_pkg.sv
package mcs_pkg;

    // Half-cell pair {first, second} as sampled on two rising edges
    typedef enum logic [1:0] {
        SYM_SOF  = 2'b00,
        SYM_ZERO = 2'b01,
        SYM_ONE  = 2'b10,
        SYM_EOF  = 2'b11
    } sym_e;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_SOF2,
        RX_ADDR,
        RX_EOF,
        RX_STREAM,
        RX_QUIET
    } rx_state_e;

endpackage

// File: rtl/mcs_frame_rx.sv
module mcs_frame_rx
    import mcs_pkg::*;
#(
    parameter int CH_W          = 4,
    parameter int MOD_W         = 4,
    parameter int STREAM_HALVES = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dl_in,
    input  logic             hold,
    input  logic [MOD_W-1:0] mod_addr,
    output logic [CH_W-1:0]  chan_sel,
    output logic             chan_valid,
    output logic             frame_err,
    output logic             rx_idle
);

    localparam int ADDR_W = CH_W + MOD_W;
    localparam int BCNT_W = $clog2(ADDR_W);
    localparam int SCNT_W = (STREAM_HALVES > 1) ? $clog2(STREAM_HALVES) : 1;
    localparam logic [BCNT_W-1:0] BIT_LAST  = BCNT_W'(ADDR_W - 1);
    localparam logic [SCNT_W-1:0] HALF_LAST = SCNT_W'(STREAM_HALVES - 1);

    typedef struct packed {
        rx_state_e          state;
        logic               half;
        logic               first;
        logic [ADDR_W-1:0]  shreg;
        logic [BCNT_W-1:0]  bcnt;
        logic [SCNT_W-1:0]  scnt;
        logic [CH_W-1:0]    chan;
        logic               err;
    } rx_t;

    rx_t rx_d, rx_q;
    sym_e sym;

    always_comb begin
        rx_d     = rx_q;
        rx_d.err = 1'b0;
        sym      = sym_e'({rx_q.first, dl_in});
        case (rx_q.state)
            RX_IDLE: begin
                if (!hold && !dl_in) rx_d.state = RX_SOF2;
            end
            RX_SOF2: begin
                if (hold) begin
                    rx_d.state = RX_IDLE;
                end else if (!dl_in) begin
                    rx_d.state = RX_ADDR;
                    rx_d.half  = 1'b0;
                    rx_d.bcnt  = '0;
                end else begin
                    rx_d.err   = 1'b1;
                    rx_d.state = RX_IDLE;
                end
            end
            RX_ADDR: begin
                if (hold) begin
                    rx_d.state = RX_IDLE;
                end else if (!rx_q.half) begin
                    rx_d.first = dl_in;
                    rx_d.half  = 1'b1;
                end else begin
                    rx_d.half = 1'b0;
                    if (sym == SYM_ONE || sym == SYM_ZERO) begin
                        rx_d.shreg = {rx_q.shreg[ADDR_W-2:0], (sym == SYM_ONE)};
                        rx_d.bcnt  = rx_q.bcnt + 1'b1;
                        if (rx_q.bcnt == BIT_LAST) rx_d.state = RX_EOF;
                    end else begin
                        rx_d.err   = 1'b1;
                        rx_d.state = RX_IDLE;
                    end
                end
            end
            RX_EOF: begin
                if (hold) begin
                    rx_d.state = RX_IDLE;
                end else if (!rx_q.half) begin
                    rx_d.first = dl_in;
                    rx_d.half  = 1'b1;
                end else begin
                    rx_d.half = 1'b0;
                    rx_d.scnt = '0;
                    if (sym == SYM_EOF) begin
                        if (rx_q.shreg[MOD_W-1:0] == mod_addr) begin
                            rx_d.state = RX_STREAM;
                            rx_d.chan  = rx_q.shreg[ADDR_W-1 -: CH_W];
                        end else begin
                            rx_d.state = RX_QUIET;
                        end
                    end else begin
                        rx_d.err   = 1'b1;
                        rx_d.state = RX_IDLE;
                    end
                end
            end
            RX_STREAM, RX_QUIET: begin
                if (rx_q.scnt == HALF_LAST) rx_d.state = RX_IDLE;
                else                        rx_d.scnt  = rx_q.scnt + 1'b1;
            end
            default: rx_d.state = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q       <= '0;
            rx_q.state <= RX_IDLE;
        end else begin
            rx_q <= rx_d;
        end
    end

    assign chan_sel   = rx_q.chan;
    assign chan_valid = (rx_q.state == RX_STREAM);
    assign frame_err  = rx_q.err;
    assign rx_idle    = (rx_q.state == RX_IDLE);

endmodule

// File: rtl/mcs_req_tx.sv
module mcs_req_tx #(
    parameter int IRQ_HALVES = 4,
    parameter int SRQ_HALVES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic irq_req,
    input  logic irq_en,
    input  logic srq_req,
    input  logic bus_idle,
    output logic busy,
    output logic is_irq
);

    localparam int MAX_H = (IRQ_HALVES > SRQ_HALVES) ? IRQ_HALVES : SRQ_HALVES;
    localparam int CNT_W = $clog2(MAX_H) + 1;
    localparam logic [CNT_W-1:0] IRQ_LAST = CNT_W'(IRQ_HALVES - 1);
    localparam logic [CNT_W-1:0] SRQ_LAST = CNT_W'(SRQ_HALVES - 1);

    typedef struct packed {
        logic             irq_pend;
        logic             srq_pend;
        logic             busy;
        logic             is_irq;
        logic [CNT_W-1:0] cnt;
    } tx_t;

    tx_t tx_d, tx_q;

    always_comb begin
        tx_d = tx_q;
        if (irq_req && irq_en) tx_d.irq_pend = 1'b1;
        if (srq_req)           tx_d.srq_pend = 1'b1;
        if (tx_q.busy) begin
            if (tx_q.cnt == '0) tx_d.busy = 1'b0;
            else                tx_d.cnt  = tx_q.cnt - 1'b1;
        end else if (tx_q.irq_pend) begin
            tx_d.busy     = 1'b1;
            tx_d.is_irq   = 1'b1;
            tx_d.cnt      = IRQ_LAST;
            tx_d.irq_pend = irq_req && irq_en;
        end else if (tx_q.srq_pend && bus_idle) begin
            tx_d.busy     = 1'b1;
            tx_d.is_irq   = 1'b0;
            tx_d.cnt      = SRQ_LAST;
            tx_d.srq_pend = srq_req;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tx_q <= '0;
        else        tx_q <= tx_d;
    end

    assign busy   = tx_q.busy;
    assign is_irq = tx_q.is_irq;

endmodule

// File: rtl/mcs_chan_mux.sv
module mcs_chan_mux #(
    parameter int N_CH = 16,
    parameter int CH_W = 4
) (
    input  logic [N_CH-1:0] freq_in,
    input  logic [CH_W-1:0] sel,
    output logic            freq_out
);

    logic [N_CH-1:0] hit;

    for (genvar g = 0; g < N_CH; g++) begin : g_tap
        assign hit[g] = freq_in[g] && (sel == CH_W'(g));
    end

    assign freq_out = |hit;

endmodule

// File: rtl/mcs_sensor_slave.sv
module mcs_sensor_slave #(
    parameter int N_CH          = 16,
    parameter int MOD_W         = 4,
    parameter int STREAM_HALVES = 16,
    parameter int IRQ_HALVES    = 4,
    parameter int SRQ_HALVES    = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    dl_in,
    input  logic [MOD_W-1:0]        mod_addr,
    input  logic [N_CH-1:0]         freq_in,
    input  logic                    irq_req,
    input  logic                    irq_en,
    input  logic                    srq_req,
    output logic                    dl_oe,
    output logic [$clog2(N_CH)-1:0] chan_sel,
    output logic                    chan_valid,
    output logic                    frame_err
);

    localparam int CH_W = $clog2(N_CH);

    logic tx_busy;
    logic tx_is_irq;
    logic rx_idle;
    logic freq_bit;

    mcs_frame_rx #(
        .CH_W          (CH_W),
        .MOD_W         (MOD_W),
        .STREAM_HALVES (STREAM_HALVES)
    ) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .dl_in      (dl_in),
        .hold       (tx_busy),
        .mod_addr   (mod_addr),
        .chan_sel   (chan_sel),
        .chan_valid (chan_valid),
        .frame_err  (frame_err),
        .rx_idle    (rx_idle)
    );

    mcs_req_tx #(
        .IRQ_HALVES (IRQ_HALVES),
        .SRQ_HALVES (SRQ_HALVES)
    ) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .irq_req  (irq_req),
        .irq_en   (irq_en),
        .srq_req  (srq_req),
        .bus_idle (rx_idle && dl_in),
        .busy     (tx_busy),
        .is_irq   (tx_is_irq)
    );

    mcs_chan_mux #(
        .N_CH (N_CH),
        .CH_W (CH_W)
    ) u_mux (
        .freq_in  (freq_in),
        .sel      (chan_sel),
        .freq_out (freq_bit)
    );

    // Open-drain: pull low for a request, or when the routed channel is low
    assign dl_oe = tx_busy || (chan_valid && !freq_bit);

endmodule

// File: rtl/mcs_sensor_slave_chk.sv
module mcs_sensor_slave_chk #(
    parameter int CH_W = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            dl_oe,
    input logic [CH_W-1:0] chan_sel,
    input logic            chan_valid,
    input logic            frame_err,
    input logic            tx_busy,
    input logic            tx_is_irq,
    input logic            rx_idle
);

    // R11
    dl_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_busy && !chan_valid) |-> !dl_oe);

    // R6
    req_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_busy |-> dl_oe);

    // R3
    sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_valid && $past(chan_valid)) |-> $stable(chan_sel));

    // R5
    err_nosel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |-> !chan_valid);

    // R9
    srq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(tx_busy) && !tx_is_irq) |-> $past(rx_idle));

endmodule

bind mcs_sensor_slave mcs_sensor_slave_chk #(.CH_W(CH_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .dl_oe      (dl_oe),
    .chan_sel   (chan_sel),
    .chan_valid (chan_valid),
    .frame_err  (frame_err),
    .tx_busy    (tx_busy),
    .tx_is_irq  (tx_is_irq),
    .rx_idle    (rx_idle)
);

// File: tb/mcs_sensor_slave_tb.sv
module mcs_sensor_slave_tb;

    localparam int CLK_PERIOD = 10;
    localparam int N_CH       = 16;
    localparam int NSTR       = 16;
    localparam int NIRQ       = 4;
    localparam logic [3:0] MY_MOD = 4'h9;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            dl_ctrl;
    logic            dl_in;
    logic [3:0]      mod_addr;
    logic [N_CH-1:0] freq_in;
    logic            irq_req, irq_en, srq_req;
    logic            dl_oe;
    logic [3:0]      chan_sel;
    logic            chan_valid, frame_err;

    int checks = 0;
    int fails  = 0;

    assign dl_in = dl_ctrl & ~dl_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    mcs_sensor_slave u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .dl_in      (dl_in),
        .mod_addr   (mod_addr),
        .freq_in    (freq_in),
        .irq_req    (irq_req),
        .irq_en     (irq_en),
        .srq_req    (srq_req),
        .dl_oe      (dl_oe),
        .chan_sel   (chan_sel),
        .chan_valid (chan_valid),
        .frame_err  (frame_err)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Drive one half-cell from a falling edge to the next falling edge
    task automatic put(input logic v);
        dl_ctrl = v;
        @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        if (b) begin put(1'b1); put(1'b0); end
        else   begin put(1'b0); put(1'b1); end
    endtask

    task automatic send_frame(input logic [3:0] ch, input logic [3:0] md);
        put(1'b0); put(1'b0);
        for (int i = 3; i >= 0; i--) send_bit(ch[i]);
        for (int i = 3; i >= 0; i--) send_bit(md[i]);
        put(1'b1); put(1'b1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; dl_ctrl = 1'b1; mod_addr = MY_MOD; freq_in = '1;
        irq_req = 1'b0; irq_en = 1'b0; srq_req = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 oe in reset", 32'(dl_oe), 0);
        chk("R1 valid in reset", 32'(chan_valid), 0);
        rst_n = 1'b1;
        chk("R1 err after reset", 32'(frame_err), 0);
        put(1'b1);
        chk("R1 oe after release", 32'(dl_oe), 0);

        // R2 / R3: every channel selected and streamed
        for (int ch = 0; ch < 16; ch++) begin
            send_frame(4'(ch), MY_MOD);
            chk("R2 chan_valid", 32'(chan_valid), 1);
            chk("R2 chan_sel", 32'(chan_sel), 32'(ch));
            for (int k = 0; k < NSTR; k++) begin
                logic [15:0] pat;
                pat = 16'h1 << ((ch + k) % 16);
                freq_in = (k % 2 == 0) ? ~pat : pat;
                #1;
                chk("R3 routed level", 32'(dl_oe), 32'(!freq_in[ch]));
                chk("R3 still selected", 32'(chan_valid), 1);
                put(1'b1);
            end
            chk("R3 stream ended", 32'(chan_valid), 0);
            chk("R3 line released", 32'(dl_oe), 0);
        end
        freq_in = '1;

        // R4: every other module number, peer traffic in the quiet window
        for (int m = 0; m < 16; m++) begin
            if (4'(m) != MY_MOD) begin
                send_frame(4'h3, 4'(m));
                chk("R4 no select", 32'(chan_valid), 0);
                for (int k = 0; k < NSTR; k++) begin
                    put(1'(k % 2));
                    chk("R4 no error", 32'(frame_err), 0);
                    chk("R4 oe low", 32'(dl_oe), 0);
                end
                put(1'b1);
                chk("R4 still unselected", 32'(chan_valid), 0);
            end
        end
        send_frame(4'h7, MY_MOD);
        chk("R4 receiver recovered", 32'(chan_sel), 7);
        repeat (NSTR) put(1'b1);

        // R5: framing errors
        put(1'b0); put(1'b1);
        chk("R5 bad start", 32'(frame_err), 1);
        put(1'b1);
        chk("R5 pulse one cycle", 32'(frame_err), 0);
        put(1'b0); put(1'b0); send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        put(1'b0); put(1'b0);
        chk("R5 start inside address", 32'(frame_err), 1);
        put(1'b1);
        put(1'b0); put(1'b0); send_bit(1'b0); send_bit(1'b1);
        put(1'b1); put(1'b1);
        chk("R5 end inside address", 32'(frame_err), 1);
        put(1'b1);
        put(1'b0); put(1'b0);
        for (int i = 3; i >= 0; i--) send_bit(1'b0);
        for (int i = 3; i >= 0; i--) send_bit(MY_MOD[i]);
        put(1'b1); put(1'b0);
        chk("R5 missing end", 32'(frame_err), 1);
        chk("R5 no select", 32'(chan_valid), 0);
        put(1'b1); put(1'b1);
        send_frame(4'hC, MY_MOD);
        chk("R5 valid after errors", 32'(chan_sel), 12);
        repeat (NSTR) put(1'b1);

        // R6: interrupt from idle
        irq_en = 1'b1; irq_req = 1'b1;
        put(1'b1);
        irq_req = 1'b0;
        chk("R6 not yet", 32'(dl_oe), 0);
        for (int i = 0; i < NIRQ; i++) begin
            put(1'b1);
            chk("R6 irq drive", 32'(dl_oe), 1);
        end
        put(1'b1);
        chk("R6 irq done", 32'(dl_oe), 0);

        // R7: masked interrupt dropped
        irq_en = 1'b0; irq_req = 1'b1;
        put(1'b1);
        irq_req = 1'b0;
        for (int i = 0; i < NIRQ + 3; i++) begin
            put(1'b1);
            chk("R7 masked", 32'(dl_oe), 0);
        end
        irq_en = 1'b1;
        for (int i = 0; i < NIRQ + 2; i++) begin
            put(1'b1);
            chk("R7 not replayed", 32'(dl_oe), 0);
        end

        // R6: interrupt overrides a stream without stretching it
        send_frame(4'h5, MY_MOD);
        freq_in = '1;
        put(1'b1);
        irq_req = 1'b1;
        put(1'b1);
        irq_req = 1'b0;
        chk("R6 stream level", 32'(dl_oe), 0);
        for (int i = 0; i < NIRQ; i++) begin
            put(1'b1);
            chk("R6 override stream", 32'(dl_oe), 1);
        end
        for (int k = 0; k < NSTR - 2 - NIRQ; k++) begin
            chk("R6 stream continues", 32'(chan_valid), 1);
            put(1'b1);
        end
        chk("R6 stream length kept", 32'(chan_valid), 0);

        // R8: interrupt during frame reception
        put(1'b0); put(1'b0); send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        irq_req = 1'b1;
        put(1'b1);
        irq_req = 1'b0;
        put(1'b0);
        chk("R8 no error", 32'(frame_err), 0);
        for (int i = 0; i < NIRQ + 1; i++) begin
            put(1'b1);
            chk("R8 no error while sending", 32'(frame_err), 0);
        end
        chk("R8 frame dropped", 32'(chan_valid), 0);
        send_frame(4'hA, MY_MOD);
        chk("R8 next frame", 32'(chan_sel), 10);
        chk("R8 next frame valid", 32'(chan_valid), 1);
        repeat (NSTR) put(1'b1);

        // R9: service request from idle
        srq_req = 1'b1;
        put(1'b1);
        srq_req = 1'b0;
        chk("R9 not yet", 32'(dl_oe), 0);
        put(1'b1); chk("R9 srq drive a", 32'(dl_oe), 1);
        put(1'b1); chk("R9 srq drive b", 32'(dl_oe), 1);
        put(1'b1); chk("R9 srq done", 32'(dl_oe), 0);

        // R9: service request deferred until stream end
        send_frame(4'h2, MY_MOD);
        freq_in = '1;
        srq_req = 1'b1;
        put(1'b1);
        srq_req = 1'b0;
        for (int k = 0; k < NSTR - 1; k++) begin
            chk("R9 held during stream", 32'(dl_oe), 0);
            put(1'b1);
        end
        chk("R9 stream over", 32'(chan_valid), 0);
        chk("R9 still waiting", 32'(dl_oe), 0);
        put(1'b1); chk("R9 deferred a", 32'(dl_oe), 1);
        put(1'b1); chk("R9 deferred b", 32'(dl_oe), 1);
        put(1'b1); chk("R9 deferred done", 32'(dl_oe), 0);

        // R10: interrupt ahead of service request
        irq_req = 1'b1; srq_req = 1'b1;
        put(1'b1);
        irq_req = 1'b0; srq_req = 1'b0;
        chk("R10 idle", 32'(dl_oe), 0);
        for (int i = 0; i < NIRQ; i++) begin
            put(1'b1);
            chk("R10 irq first", 32'(dl_oe), 1);
        end
        put(1'b1); chk("R10 gap", 32'(dl_oe), 0);
        put(1'b1); chk("R10 srq a", 32'(dl_oe), 1);
        put(1'b1); chk("R10 srq b", 32'(dl_oe), 1);
        put(1'b1); chk("R10 done", 32'(dl_oe), 0);
        chk("R11 released at end", 32'(dl_oe), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule